// File: doc/BRIEF.md
# Dual-Channel Dithered PWM Generator

This block drives two PWM pins from two 16-bit duty words. The period on each pin is short (the native period), so the switching rate stays high. The fine resolution of the duty word is not lost. Each duty word is split into a coarse part and a fine part. The coarse part sets the high time in clocks within one native period. The fine part feeds a per-channel carry accumulator. On the native periods where the accumulator overflows, the high time gets one extra clock. Over a dither group of several native periods, the average duty therefore matches the full 16-bit word.

Channel B runs half a native period behind channel A, so the two edges never coincide. Each duty word is captured once per dither group, at that channel's own group start, and is held for the rest of the group.

Parameters choose the total resolution, the native period and the channel count. A further parameter selects the non-dithered variant, in which the whole duty word is compared against one full-resolution period. In the single-channel variant the B pin stays low.

Top module: `pwm_dither_dual`

## Requirements
- R1: While rst_n is low, both PWM outputs are low, all accumulators are zero and the period counter is zero.
- R2: With dithering on, the native period is P = 2^NATIVE_BITS clocks. Edges are numbered from 0, where edge 0 is the first rising clock edge after reset release. Channel A periods begin at edges that are multiples of P. After the edge at position p of a period, the output shows the high/low state for p, and a rising output happens only at p = 0.
- R3: The number of stepping bits is S = TOTAL_BITS - NATIVE_BITS. The coarse high time is the duty word shifted right by S. The fine value is the low S bits of the duty word.
- R4: At each period start, the fine value is added into an S-bit accumulator. A carry out gives a high time of coarse+1 clocks; otherwise the high time is coarse clocks. Over any 2^TOTAL_BITS consecutive clocks at a constant duty, the count of high clocks is min(duty, 2^TOTAL_BITS).
- R5: A channel samples its duty word only at its group start, which is every 2^TOTAL_BITS clocks. A change in the middle of a group has no effect until the next group start.
- R6: Channel B uses the same timing shifted by P/2 clocks. Its periods and groups begin at edges congruent to P/2 modulo the period and group lengths.
- R7: A duty word of 0 keeps the output constantly low.
- R8: A computed high time of at least P makes the output constantly high. This holds for any duty word of at least 2^TOTAL_BITS.
- R9: With NUM_CH = 1, pwm_b stays low and duty_b has no effect.
- R10: With DITHER_EN = 0, the period is 2^TOTAL_BITS clocks and the high time equals the duty word directly, saturating at the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| duty_a | input | 16 | Duty word for channel A, in clocks per dither group |
| duty_b | input | 16 | Duty word for channel B, in clocks per dither group |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin, offset by half a native period |

## Verification
A reduced configuration (64-clock group, 16-clock native period, two stepping bits) is swept over every duty value from 0 to just above full scale on both channels at once. Complementary duty values separate the channels. Per-period high counts show the coarse part and the exact number of periods stretched by a carry. The group total shows that dithering restores the full resolution, and the endpoint values show the constant-low and constant-high cases. A fixed pattern after reset checks the period alignment and the half-period offset of channel B. A duty change in the middle of a group shows the hold until the next group start. A second non-dithered single-channel instance separates direct comparison from dithering and confirms that its B pin stays idle.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

  localparam int DUTY_W = 16;
  localparam int POS_W  = 16;

  // Per-channel view of the shared time base
  typedef struct packed {
    logic [POS_W-1:0] pos;        // clock position inside the current period
    logic             per_start;  // first clock of a period
    logic             grp_start;  // first clock of a dither group
  } pwm_phase_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dither_pkg::*;
#(
  parameter int TOTAL_BITS = 16,
  parameter int PER_BITS   = 8,
  parameter int NUM_CH     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output pwm_phase_t ph [NUM_CH]
);

  localparam logic [TOTAL_BITS-1:0] HALF = TOTAL_BITS'(1) << (PER_BITS - 1);

  logic [TOTAL_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + TOTAL_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [TOTAL_BITS-1:0] OFF = (i == 0) ? '0 : HALF;
    logic [TOTAL_BITS-1:0] loc;
    assign loc             = cnt_q - OFF;
    assign ph[i].pos       = POS_W'(loc[PER_BITS-1:0]);
    assign ph[i].per_start = (loc[PER_BITS-1:0] == '0);
    assign ph[i].grp_start = (loc == '0);
  end

endmodule

// File: rtl/pwm_carry_acc.sv
module pwm_carry_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic         carry
);

  logic [W-1:0] acc_q, acc_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, addend};
    carry = sum[W];
    acc_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_dither_pkg::*;
#(
  parameter int TOTAL_BITS = 16,
  parameter int PER_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwm_phase_t        ph,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm
);

  localparam int S = TOTAL_BITS - PER_BITS;

  logic [DUTY_W-1:0] coarse_q, coarse_d, coarse_sel;
  logic              carry;
  logic [DUTY_W:0]   hi_q, hi_now;
  logic              out_q, out_d;

  // coarse part: captured at the group start, bypassed in that same cycle
  always_comb begin
    coarse_d   = duty >> S;
    coarse_sel = ph.grp_start ? coarse_d : coarse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            coarse_q <= '0;
    else if (ph.grp_start) coarse_q <= coarse_d;
  end

  if (S > 0) begin : g_dither
    logic [S-1:0] fine_q, fine_d, fine_sel;

    always_comb begin
      fine_d   = duty[S-1:0];
      fine_sel = ph.grp_start ? fine_d : fine_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            fine_q <= '0;
      else if (ph.grp_start) fine_q <= fine_d;
    end

    pwm_carry_acc #(.W(S)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ph.per_start),
      .addend (fine_sel),
      .carry  (carry)
    );
  end else begin : g_direct
    assign carry = 1'b0;
  end

  always_comb begin
    hi_now = {1'b0, coarse_sel} + (DUTY_W + 1)'(carry);
    if (ph.per_start) out_d = (hi_now != '0);
    else              out_d = ({1'b0, ph.pos} < hi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_q <= '0;
    else if (ph.per_start) hi_q <= hi_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm = out_q;

endmodule

// File: rtl/pwm_dither_dual.sv
module pwm_dither_dual
  import pwm_dither_pkg::*;
#(
  parameter int TOTAL_BITS  = 16,
  parameter int NATIVE_BITS = 8,
  parameter int NUM_CH      = 2,
  parameter bit DITHER_EN   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] duty_a,
  input  logic [15:0] duty_b,
  output logic        pwm_a,
  output logic        pwm_b
);

  localparam int PER_BITS = DITHER_EN ? NATIVE_BITS : TOTAL_BITS;

  pwm_phase_t        ph     [NUM_CH];
  logic [DUTY_W-1:0] duty_v [NUM_CH];
  logic              pwm_v  [NUM_CH];

  pwm_timebase #(
    .TOTAL_BITS (TOTAL_BITS),
    .PER_BITS   (PER_BITS),
    .NUM_CH     (NUM_CH)
  ) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph)
  );

  assign duty_v[0] = duty_a;
  assign pwm_a     = pwm_v[0];

  if (NUM_CH > 1) begin : g_two
    assign duty_v[1] = duty_b;
    assign pwm_b     = pwm_v[1];
  end else begin : g_one
    assign pwm_b = 1'b0;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_channel #(
      .TOTAL_BITS (TOTAL_BITS),
      .PER_BITS   (PER_BITS)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .ph    (ph[i]),
      .duty  (duty_v[i]),
      .pwm   (pwm_v[i])
    );
  end

endmodule

// File: rtl/pwm_dither_chk.sv
module pwm_dither_chk #(
  parameter int TOTAL_BITS  = 16,
  parameter int NATIVE_BITS = 8,
  parameter int NUM_CH      = 2,
  parameter bit DITHER_EN   = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] duty_a,
  input logic        pwm_a,
  input logic        pwm_b
);

  localparam int PER_BITS = DITHER_EN ? NATIVE_BITS : TOTAL_BITS;
  localparam int HALF     = 1 << (PER_BITS - 1);

  // independent clock count since reset, and group-wide duty classification
  logic [TOTAL_BITS-1:0] ck_q;
  logic                  zflag_q, fflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= '0;
      zflag_q <= 1'b0;
      fflag_q <= 1'b0;
    end else begin
      ck_q <= ck_q + TOTAL_BITS'(1);
      if (ck_q == '0) begin
        zflag_q <= (duty_a == 16'd0);
        fflag_q <= ({1'b0, duty_a} >= (17'd1 << TOTAL_BITS));
      end
    end
  end

  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> (ck_q[PER_BITS-1:0] == PER_BITS'(1)));

  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zflag_q |-> !pwm_a);

  assert_full_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fflag_q |-> pwm_a);

  if (NUM_CH > 1) begin : g_two
    assert_b_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_b) |-> (ck_q[PER_BITS-1:0] == PER_BITS'(HALF + 1)));
  end else begin : g_one
    assert_single_b_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_b);
  end

endmodule

bind pwm_dither_dual pwm_dither_chk #(
  .TOTAL_BITS  (TOTAL_BITS),
  .NATIVE_BITS (NATIVE_BITS),
  .NUM_CH      (NUM_CH),
  .DITHER_EN   (DITHER_EN)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .duty_a (duty_a),
  .pwm_a  (pwm_a),
  .pwm_b  (pwm_b)
);

// File: tb/tb_pwm_dither_dual.sv
`timescale 1ns/1ps
module tb_pwm_dither_dual;

  localparam int G = 64;   // group length, small config
  localparam int P = 16;   // native period
  localparam int Q = 16;   // period of the non-dithered instance

  logic        clk, rst_n;
  logic [15:0] duty_a, duty_b, duty2, duty2_b;
  logic        pwm_a, pwm_b, pwm_a2, pwm_b2;

  int e;
  int n_chk, n_fail;
  bit done;

  pwm_dither_dual #(.TOTAL_BITS(6), .NATIVE_BITS(4), .NUM_CH(2), .DITHER_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .duty_a(duty_a), .duty_b(duty_b), .pwm_a(pwm_a), .pwm_b(pwm_b));

  pwm_dither_dual #(.TOTAL_BITS(4), .NATIVE_BITS(2), .NUM_CH(1), .DITHER_EN(1'b0)) dut2 (
    .clk(clk), .rst_n(rst_n), .duty_a(duty2), .duty_b(duty2_b), .pwm_a(pwm_a2), .pwm_b(pwm_b2));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    e++;
    @(negedge clk);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", e, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mis_a, mis_b, mis_2, hi48, hi64;
    n_chk = 0; n_fail = 0; done = 0; e = -1;
    rst_n = 1'b0;
    duty_a = 16'd16; duty_b = 16'd16; duty2 = 16'd5; duty2_b = 16'd9;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check(!pwm_a && !pwm_b && !pwm_a2 && !pwm_b2, "R1 reset outputs", {pwm_a, pwm_b, pwm_a2, pwm_b2}, 0);
    rst_n = 1'b1;

    // fixed pattern: coarse 4, fine 0 on both channels (R2, R5, R6, R10)
    mis_a = 0; mis_b = 0; mis_2 = 0; hi48 = 0; hi64 = 0;
    for (int k = 0; k < 80; k++) begin
      step();
      if (e < 48 && pwm_a != ((e % P) < 4)) mis_a++;
      if (e >= 48 && e < 64 && pwm_a) hi48++;
      if (e >= 64 && pwm_a) hi64++;
      if (pwm_b != (e >= 8 && ((e - 8) % P) < 4)) mis_b++;
      if (pwm_a2 != ((e % Q) < 5)) mis_2++;
      if (e == 34) duty_a = 16'd48;   // mid-group change
    end
    check(mis_a == 0, "R2 period alignment A", mis_a, 0);
    check(mis_b == 0, "R6 half-period offset B", mis_b, 0);
    check(mis_2 == 0, "R10 direct compare alignment", mis_2, 0);
    check(hi48 == 4, "R5 mid-group change held", hi48, 4);
    check(hi64 == 12, "R5 new duty at next group", hi64, 12);

    // sweep every duty value around full scale
    for (int d = 0; d < 68; d++) begin
      int sa, sb, s2, b2hi, plus, badch, bad2, db, d2;
      int ca [4];
      int c2 [4];
      db = 67 - d;
      d2 = d % 20;
      duty_a = 16'(d); duty_b = 16'(db); duty2 = 16'(d2); duty2_b = 16'(d);
      repeat (2 * G) step();
      while ((e % G) != G - 1) step();
      sa = 0; sb = 0; s2 = 0; b2hi = 0;
      for (int j = 0; j < 4; j++) begin ca[j] = 0; c2[j] = 0; end
      for (int k = 0; k < G; k++) begin
        step();
        if (pwm_a) begin sa++; ca[k / P]++; end
        if (pwm_b) sb++;
        if (pwm_a2) begin s2++; c2[k / Q]++; end
        if (pwm_b2) b2hi++;
      end
      if (d == 0)       check(sa == 0, "R7 zero duty low", sa, 0);
      else if (d >= G)  check(sa == G, "R8 full duty high", sa, G);
      else              check(sa == d, "R4 group sum A", sa, d);
      check(sb == imin(db, G), (db >= G) ? "R8 group sum B" : "R4 group sum B", sb, imin(db, G));
      if (d < G) begin
        plus = 0; badch = 0;
        for (int j = 0; j < 4; j++) begin
          if (ca[j] == (d >> 2) + 1) plus++;
          else if (ca[j] != (d >> 2)) badch++;
        end
        check(badch == 0 && plus == (d & 3), "R3 coarse/fine split", plus, d & 3);
      end
      bad2 = 0;
      for (int j = 0; j < 4; j++) if (c2[j] != imin(d2, Q)) bad2++;
      check(bad2 == 0 && s2 == 4 * imin(d2, Q), "R10 non-dithered high time", s2, 4 * imin(d2, Q));
      check(b2hi == 0, "R9 single channel B idle", b2hi, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule